// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block generates the colour subcarrier phase for a composite video encoder. A 26-bit numerically controlled oscillator advances by a programmable 24-bit frequency word on every 27 MHz pixel clock. The top bits of the accumulator, rotated by a programmable 9-bit offset relative to horizontal sync, form a phase word. The downstream modulator uses this phase word to address its sine and cosine tables.

Two corrections keep the oscillator on frequency over long stretches of video. First, a small adjust value is added once in every eight fields to recover the rounding lost in the frequency word. Second, when the encoder runs in the 525-line mode, the accumulator is cleared at each line end so that line length errors do not build up; a control input disables this clear. In the 625-line mode the block also delivers the burst phase, which swings between +135° and −135° on alternate lines. The sign of the swing comes from an internal line toggle or from an external identification input.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, the field counter and the line toggle are cleared. After that edge, `phase_out` equals `phase_ofs` and `pal_neg` is 0 unless `ext_id_en` selects a high `ext_id`.
- R2: On each clock edge without a line clear, the 26-bit accumulator advances by the zero-extended 24-bit `freq_word`, modulo 2^26.
- R3: `phase_out` is accumulator bits [25:17] plus `phase_ofs`, modulo 512.
- R4: The field counter counts `field_start` pulses modulo 8. The pulse that arrives while the counter holds 7 (the 8th, 16th, ... pulse after reset) also adds the zero-extended `adj_val` to the accumulator in that same edge. No other pulse adds it.
- R5: When `pal_mode` is 0, `line_rst_dis` is 0 and `line_end` is high at an edge, the accumulator becomes 0. This clear takes priority over both the frequency step and the field correction. The field counter still advances on that edge.
- R6: When `line_rst_dis` is 1 or `pal_mode` is 1, `line_end` has no effect on the accumulator.
- R7: The internal line toggle inverts on every edge where `pal_mode` and `line_start` are both high, and holds its value otherwise.
- R8: When `ext_id_en` is 1, `pal_neg` follows `ext_id` (0 selects +135°, 1 selects −135°). Otherwise `pal_neg` follows the internal line toggle.
- R9: `burst_phase` is `phase_out` plus 192 (+135°) when `pal_mode` is 1 and `pal_neg` is 0, plus 320 (−135°) when `pal_mode` is 1 and `pal_neg` is 1, and plus 256 (180°) when `pal_mode` is 0. All sums are modulo 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | 24 | Oscillator step per clock |
| adj_val | input | 8 | Correction added once every eight fields |
| phase_ofs | input | 9 | Phase offset relative to sync, nominal zero |
| pal_mode | input | 1 | 1 = 625-line alternating mode, 0 = 525-line mode |
| line_rst_dis | input | 1 | 1 = suppress the line-end accumulator clear |
| line_start | input | 1 | Single-cycle pulse at the start of each line |
| line_end | input | 1 | Single-cycle pulse at the end of each line |
| field_start | input | 1 | Single-cycle pulse at the start of each field |
| ext_id_en | input | 1 | 1 = take the burst sign from `ext_id` |
| ext_id | input | 1 | External burst sign: 0 = +135°, 1 = −135° |
| phase_out | output | 9 | Subcarrier phase to the sine/cosine lookup |
| burst_phase | output | 9 | Burst phase with the line-dependent rotation |
| pal_neg | output | 1 | Burst sign in effect: 1 = −135° |

## Verification
The bench uses the default widths: a 24-bit frequency word, a 26-bit accumulator, a 9-bit phase and an eight-field correction period. With these widths one adjust step is only visible at the 9-bit output when it carries into bit 17. The bench therefore first parks the accumulator at 2^17−1, so that a single unit of correction moves the phase by one. Because field pulses are driven directly rather than waited for over real field lengths, the eight-field cycle, its overlap with a line clear and many line toggles all fit within a few thousand clocks. The run mixes the three broadcast frequency words with random words to exercise accumulator wrap.

// File: rtl/scp_pkg.sv
// Package: shared types for the subcarrier phase accumulator.
// Assumes: nothing beyond the single-bit sign encoding below.
package scp_pkg;
    // Burst sign in the alternating-line mode.
    typedef enum logic {
        SGN_PLUS  = 1'b0,   // +135 degrees
        SGN_MINUS = 1'b1    // -135 degrees
    } pal_sign_e;
endpackage

// File: rtl/scp_field_corr.sv
// Module: scp_field_corr
// Counts field start pulses and raises a one-cycle correction strobe on
// the pulse that completes each group of FIELDS fields.
// Assumes: field_start is a single-cycle pulse; FIELDS >= 1.
module scp_field_corr #(
    parameter int FIELDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_start,
    output logic corr_stb
);
    localparam int CW = (FIELDS > 1) ? $clog2(FIELDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(FIELDS - 1);

    logic [CW-1:0] fcnt_q;
    logic          at_last;

    assign at_last  = (fcnt_q == LAST);
    assign corr_stb = field_start && at_last;

    // Advance the field count on each field pulse, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (field_start) begin
            fcnt_q <= at_last ? '0 : fcnt_q + 1'b1;
        end
    end

    // R4
    fcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(fcnt_q));
endmodule

// File: rtl/scp_nco.sv
// Module: scp_nco
// Phase accumulator: adds the frequency word every clock, adds the
// correction value when strobed, and clears on a line clear request.
// Assumes: ACC_W >= FREQ_W, ACC_W >= ADJ_W, ACC_W >= PH_W.
module scp_nco #(
    parameter int FREQ_W = 24,
    parameter int ACC_W  = 26,
    parameter int ADJ_W  = 8,
    parameter int PH_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic [ADJ_W-1:0]  adj_val,
    input  logic              corr_stb,
    input  logic              line_clr,
    output logic [PH_W-1:0]   ph_msb
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] corr_term;

    // Select the correction term for this cycle.
    always_comb begin
        corr_term = corr_stb ? ACC_W'(adj_val) : '0;
    end

    // Form the next accumulator value; the line clear wins over all steps.
    always_comb begin
        if (line_clr) begin
            acc_d = '0;
        end else begin
            acc_d = acc_q + ACC_W'(freq_word) + corr_term;
        end
    end

    // Hold the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign ph_msb = acc_q[ACC_W-1 -: PH_W];

    // R5
    line_clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_clr |=> (acc_q == '0));

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_clr && !corr_stb) |=>
            (acc_q == $past(acc_q) + ACC_W'($past(freq_word))));

    // R4
    corr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_clr && corr_stb) |=>
            (acc_q == $past(acc_q) + ACC_W'($past(freq_word))
                                   + ACC_W'($past(adj_val))));
endmodule

// File: rtl/scp_pal_switch.sv
// Module: scp_pal_switch
// Keeps the alternating-line toggle and selects the burst sign from the
// toggle or from the external identification input.
// Assumes: line_start is a single-cycle pulse.
module scp_pal_switch
    import scp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pal_mode,
    input  logic      line_start,
    input  logic      ext_id_en,
    input  logic      ext_id,
    output pal_sign_e sign
);
    logic tog_q;

    // Flip the toggle at each line start in the alternating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (pal_mode && line_start) begin
            tog_q <= ~tog_q;
        end
    end

    // Choose the sign source.
    always_comb begin
        sign = pal_sign_e'(ext_id_en ? ext_id : tog_q);
    end

    // R7
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_mode && line_start) |=> (tog_q != $past(tog_q)));

    // R7
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_mode && line_start) |=> $stable(tog_q));
endmodule

// File: rtl/scp_phase_map.sv
// Module: scp_phase_map
// Adds the sync-relative offset to the accumulator top bits and applies
// the burst rotation for the active line standard.
// Assumes: PH_W >= 3 so that 135 degrees is an exact step count.
module scp_phase_map
    import scp_pkg::*;
#(
    parameter int PH_W = 9
) (
    input  logic [PH_W-1:0] ph_msb,
    input  logic [PH_W-1:0] phase_ofs,
    input  logic            pal_mode,
    input  pal_sign_e       sign,
    output logic [PH_W-1:0] phase_out,
    output logic [PH_W-1:0] burst_phase
);
    localparam logic [PH_W-1:0] ROT_HALF = PH_W'(2 ** (PH_W - 1));
    localparam logic [PH_W-1:0] ROT_POS  = PH_W'(3 * (2 ** (PH_W - 3)));
    localparam logic [PH_W-1:0] ROT_NEG  = PH_W'((2 ** PH_W) - 3 * (2 ** (PH_W - 3)));

    logic [PH_W-1:0] rot;

    // Pick the burst rotation for the current standard and sign.
    always_comb begin
        if (!pal_mode) begin
            rot = ROT_HALF;
        end else if (sign == SGN_MINUS) begin
            rot = ROT_NEG;
        end else begin
            rot = ROT_POS;
        end
    end

    // Modulo additions for the two phase outputs.
    always_comb begin
        phase_out   = ph_msb + phase_ofs;
        burst_phase = phase_out + rot;
    end
endmodule

// File: rtl/subcarrier_phase_gen.sv
// Module: subcarrier_phase_gen
// Top of the subcarrier phase accumulator: field correction counter,
// accumulator, alternating-line switch and phase mapping.
// Assumes: line_start, line_end and field_start are single-cycle pulses
// on the pixel clock; reset is synchronous and active low.
module subcarrier_phase_gen
    import scp_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int ACC_W  = 26,
    parameter int ADJ_W  = 8,
    parameter int PH_W   = 9,
    parameter int FIELDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic [ADJ_W-1:0]  adj_val,
    input  logic [PH_W-1:0]   phase_ofs,
    input  logic              pal_mode,
    input  logic              line_rst_dis,
    input  logic              line_start,
    input  logic              line_end,
    input  logic              field_start,
    input  logic              ext_id_en,
    input  logic              ext_id,
    output logic [PH_W-1:0]   phase_out,
    output logic [PH_W-1:0]   burst_phase,
    output logic              pal_neg
);
    localparam logic [PH_W-1:0] CHK_POS = PH_W'(3 * (2 ** (PH_W - 3)));
    localparam logic [PH_W-1:0] CHK_NEG = PH_W'((2 ** PH_W) - 3 * (2 ** (PH_W - 3)));

    logic            corr_stb;
    logic            line_clr;
    logic [PH_W-1:0] ph_msb;
    pal_sign_e       sign;

    // Line clear only in the 525-line mode and only when not disabled.
    always_comb begin
        line_clr = line_end && !pal_mode && !line_rst_dis;
    end

    scp_field_corr #(
        .FIELDS (FIELDS)
    ) u_fcorr (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .corr_stb    (corr_stb)
    );

    scp_nco #(
        .FREQ_W (FREQ_W),
        .ACC_W  (ACC_W),
        .ADJ_W  (ADJ_W),
        .PH_W   (PH_W)
    ) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .adj_val   (adj_val),
        .corr_stb  (corr_stb),
        .line_clr  (line_clr),
        .ph_msb    (ph_msb)
    );

    scp_pal_switch u_psw (
        .clk        (clk),
        .rst_n      (rst_n),
        .pal_mode   (pal_mode),
        .line_start (line_start),
        .ext_id_en  (ext_id_en),
        .ext_id     (ext_id),
        .sign       (sign)
    );

    scp_phase_map #(
        .PH_W (PH_W)
    ) u_map (
        .ph_msb      (ph_msb),
        .phase_ofs   (phase_ofs),
        .pal_mode    (pal_mode),
        .sign        (sign),
        .phase_out   (phase_out),
        .burst_phase (burst_phase)
    );

    assign pal_neg = (sign == SGN_MINUS);

    // R8
    ext_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_mode && ext_id_en) |->
            (PH_W'(burst_phase - phase_out) == (ext_id ? CHK_NEG : CHK_POS)));
endmodule

// File: tb/subcarrier_phase_gen_tb.sv
module subcarrier_phase_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] freq_word;
    logic [7:0]  adj_val;
    logic [8:0]  phase_ofs;
    logic        pal_mode, line_rst_dis, line_start, line_end, field_start;
    logic        ext_id_en, ext_id;
    logic [8:0]  phase_out, burst_phase;
    logic        pal_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [25:0] m_acc;
    int          m_fc;
    bit          m_tog;

    always #4 clk = ~clk;

    subcarrier_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .adj_val(adj_val),
        .phase_ofs(phase_ofs), .pal_mode(pal_mode), .line_rst_dis(line_rst_dis),
        .line_start(line_start), .line_end(line_end), .field_start(field_start),
        .ext_id_en(ext_id_en), .ext_id(ext_id), .phase_out(phase_out),
        .burst_phase(burst_phase), .pal_neg(pal_neg)
    );

    function automatic logic [8:0] exp_phase();
        return 9'(m_acc[25:17] + phase_ofs);
    endfunction

    function automatic bit exp_sign();
        return ext_id_en ? ext_id : m_tog;
    endfunction

    function automatic logic [8:0] exp_burst();
        logic [8:0] r;
        if (!pal_mode) r = 9'd256;
        else r = exp_sign() ? 9'd320 : 9'd192;
        return 9'(exp_phase() + r);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: update the model from the held inputs, then compare.
    task automatic tick(string tag);
        logic [25:0] nacc;
        int          nfc;
        bit          ntog;
        bit          corr, clr;
        if (!rst_n) begin
            nacc = '0; nfc = 0; ntog = 1'b0;
        end else begin
            corr = field_start && (m_fc == 7);
            clr  = line_end && !pal_mode && !line_rst_dis;
            nfc  = field_start ? ((m_fc + 1) % 8) : m_fc;
            nacc = clr ? 26'd0 : 26'(m_acc + 26'(freq_word) + (corr ? 26'(adj_val) : 26'd0));
            ntog = (pal_mode && line_start) ? ~m_tog : m_tog;
        end
        @(posedge clk);
        #1;
        m_acc = nacc; m_fc = nfc; m_tog = ntog;
        check({tag, " phase"}, int'(phase_out), int'(exp_phase()));
        check({tag, " burst"}, int'(burst_phase), int'(exp_burst()));
        check({tag, " sign"}, int'(pal_neg), int'(exp_sign()));
        @(negedge clk);
    endtask

    task automatic quiet();
        line_start = 0; line_end = 0; field_start = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_acc = '0; m_fc = 0; m_tog = 0;
        rst_n = 0; freq_word = 24'h87C1F1; adj_val = 8'h00; phase_ofs = 9'd5;
        pal_mode = 0; line_rst_dis = 0; ext_id_en = 0; ext_id = 0; quiet();
        @(negedge clk);

        // R1: reset clears state; phase equals offset
        tick("R1"); tick("R1");
        check("R1 phase==ofs", int'(phase_out), 5);
        check("R1 sign", int'(pal_neg), 0);

        rst_n = 1;
        // R3: offset sweep with the default NTSC word
        for (int i = 0; i < 20; i++) begin
            phase_ofs = 9'($urandom);
            tick("R3");
        end

        // R4: park accumulator at 2^17-1, then count field pulses
        rst_n = 0; tick("R1"); rst_n = 1;
        phase_ofs = 9'd0; line_rst_dis = 1; adj_val = 8'd1;
        freq_word = 24'h01FFFF; tick("R2");
        freq_word = 24'h0;
        for (int i = 0; i < 7; i++) begin
            field_start = 1; tick("R4 early");
            field_start = 0; tick("R4 gap");
        end
        field_start = 1; tick("R4 eighth");
        field_start = 0;
        check("R4 carry", int'(phase_out), 1);

        // R6: line_end ignored with disable set in NTSC and in PAL mode
        freq_word = 24'h0A0000; tick("R2");
        line_end = 1; tick("R6 dis");
        line_end = 0; tick("R6");
        line_rst_dis = 0; pal_mode = 1;
        line_end = 1; tick("R6 pal");
        line_end = 0; tick("R6");
        check("R6 not cleared", int'(phase_out != 0), 1);

        // R5: clear wins over step and over a coinciding correction
        pal_mode = 0;
        for (int i = 0; i < 7; i++) begin
            field_start = 1; tick("R5 pre");
            field_start = 0; tick("R5 pre");
        end
        field_start = 1; line_end = 1; adj_val = 8'hFF; tick("R5 clr+corr");
        quiet();
        check("R5 zero", int'(phase_out), 0);
        tick("R5 after");

        // R7/R8/R9: alternating toggle, external sign
        pal_mode = 1; freq_word = 24'hA8262B; adj_val = 8'h9C;
        for (int i = 0; i < 6; i++) begin
            line_start = 1; tick("R7 flip");
            line_start = 0; tick("R9");
        end
        ext_id_en = 1;
        for (int i = 0; i < 4; i++) begin
            ext_id = i[0]; line_start = 1; tick("R8 ext");
            line_start = 0; tick("R8");
        end
        ext_id_en = 0; pal_mode = 0;
        line_start = 1; tick("R7 hold ntsc");
        line_start = 0; tick("R9 ntsc");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            case ($urandom % 4)
                0: freq_word = 24'h87C1F1;
                1: freq_word = 24'hA8262B;
                2: freq_word = 24'h87DA51;
                default: freq_word = 24'($urandom);
            endcase
            adj_val = 8'($urandom);
            if ($urandom % 50 == 0) pal_mode = ~pal_mode;
            if ($urandom % 40 == 0) line_rst_dis = ~line_rst_dis;
            if ($urandom % 60 == 0) ext_id_en = ~ext_id_en;
            ext_id = 1'($urandom);
            if ($urandom % 16 == 0) phase_ofs = 9'($urandom);
            line_start  = ($urandom % 8 == 0);
            line_end    = ($urandom % 10 == 0);
            field_start = ($urandom % 6 == 0);
            rst_n       = ($urandom % 500 != 0);
            tick("R2 rand");
        end
        rst_n = 1; quiet();
        tick("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule